// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block watches the accesses presented on a memory bus and looks for a fixed run of six reads that encodes a nonvolatile command. Five reads must land on a fixed chain of addresses in order. A sixth read then selects one of four commands: save the array to nonvolatile storage, restore it from there, or turn the automatic save on power loss off or on. When the sixth read is recognised, the block raises a single-cycle command pulse together with a 2-bit code. A separate execution unit acts on that pulse.

Each access arrives as a clocked strobe. With the strobe come a cycle-type bit that marks writes, a level that shows whether write enable is asserted, and the address. Any access that does not continue the chain cancels the chain. That includes a write, a read at the wrong address, and a read while write enable is active. Only the low 16 address bits are compared. While a busy input is high, accesses are ignored and no command pulse appears.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset the command pulse is low and no partial progress survives. A reset in the middle of a chain means that the remaining steps of that chain produce no command.
- R2: The five reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, in that order, followed by a read at 0x8FC0, give one pulse with code 0 (save). The pulse is visible in the cycle after the clock edge that takes the sixth read.
- R3: The same five reads followed by a read at 0x4C63 give one pulse with code 1 (restore).
- R4: The same five reads followed by 0x8B45 give code 2 (automatic save off). Followed by 0x4B46 they give code 3 (automatic save on).
- R5: A read whose address is not the expected next step aborts the chain. Completing the rest of that chain then gives no pulse.
- R6: The aborting read is itself compared with the first chain address 0x4E38. If it matches, it counts as step one of a new chain.
- R7: An access with the cycle-type bit set (write) or with the write-enable level active is never a valid step. It returns progress to zero.
- R8: Address bits at and above bit 16 are ignored in every comparison.
- R9: A command pulse lasts exactly one cycle. The detector then starts again from zero, so a lone sixth-step read right after a command gives no pulse.
- R10: While busy is high, the pulse output stays low and strobed accesses neither advance nor abort the chain.
- R11: Cycles without a strobe leave progress unchanged, so gaps between steps are allowed.
- R12: When the pulse is low, the code output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | One-cycle strobe marking a bus access |
| acc_wr | input | 1 | Cycle type of the access: 1 = write, 0 = read |
| we_act | input | 1 | Write-enable level asserted during the access |
| acc_addr | input | ADDR_W (17) | Access address |
| busy | input | 1 | Device busy; inhibits tracking and the pulse |
| cmd_vld | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | 0 save, 1 restore, 2 auto-save off, 3 auto-save on; 0 when idle |

## Verification
The assertions check the following on every cycle: that the pulse is one cycle wide, that it is silent while busy and the code is zero when idle, and that a fire happens only from the fifth step. They also check that writes and write-enabled reads clear progress, and that progress holds through idle or busy cycles. Only the bench scenarios can show which address chains give which code. The same holds for the abort-then-restart rule, the masking of the upper address bits, and the loss of progress across reset. A behavioural model in the bench checks these against the outputs on every clock.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int CMP_W  = 16;
  localparam int NPRE   = 5;
  localparam int PROG_W = $clog2(NPRE + 1);

  typedef enum logic [1:0] {
    CMD_SAVE    = 2'd0,
    CMD_RESTORE = 2'd1,
    CMD_AS_OFF  = 2'd2,
    CMD_AS_ON   = 2'd3
  } cmd_e;

  function automatic logic [CMP_W-1:0] prefix_addr(input int unsigned idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  function automatic logic final_hit(input logic [CMP_W-1:0] a);
    return (a == 16'h8FC0) || (a == 16'h4C63) || (a == 16'h8B45) || (a == 16'h4B46);
  endfunction

  function automatic cmd_e final_code(input logic [CMP_W-1:0] a);
    case (a)
      16'h4C63: return CMD_RESTORE;
      16'h8B45: return CMD_AS_OFF;
      16'h4B46: return CMD_AS_ON;
      default:  return CMD_SAVE;
    endcase
  endfunction
endpackage

// File: rtl/seqcmd_addr_decode.sv
module seqcmd_addr_decode
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NPRE-1:0]   pre_hit,
  output logic              fin_hit,
  output cmd_e              fin_code
);
  logic [CMP_W-1:0] low_a;
  assign low_a = addr[CMP_W-1:0];

  for (genvar i = 0; i < NPRE; i++) begin : g_pre
    assign pre_hit[i] = (low_a == prefix_addr(i));
  end

  assign fin_hit  = final_hit(low_a);
  assign fin_code = final_code(low_a);
endmodule

// File: rtl/seqcmd_tracker.sv
module seqcmd_tracker
  import seqcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              rd_ok,
  input  logic [NPRE-1:0]   pre_hit,
  input  logic              fin_hit,
  output logic [PROG_W-1:0] prog_q,
  output logic              advance,
  output logic              abort,
  output logic              fire
);
  localparam int HW = 1 << PROG_W;
  localparam logic [PROG_W-1:0] LAST = PROG_W'(NPRE);

  logic [HW-1:0]     hit_ext;
  logic [PROG_W-1:0] prog_d;

  assign hit_ext = HW'(pre_hit);

  always_comb begin
    prog_d  = prog_q;
    advance = 1'b0;
    abort   = 1'b0;
    fire    = 1'b0;
    if (take) begin
      if (!rd_ok) begin
        abort  = (prog_q != '0);
        prog_d = '0;
      end else if (prog_q < LAST && hit_ext[prog_q]) begin
        advance = 1'b1;
        prog_d  = prog_q + 1'b1;
      end else if (prog_q == LAST && fin_hit) begin
        fire   = 1'b1;
        prog_d = '0;
      end else begin
        abort  = (prog_q != '0);
        prog_d = pre_hit[0] ? PROG_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prog_q <= '0;
    else        prog_q <= prog_d;
  end
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic              we_act,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy,
  output logic              cmd_vld,
  output logic [1:0]        cmd_code
);
  logic [NPRE-1:0]   pre_hit;
  logic              fin_hit;
  cmd_e              fin_code;
  logic              take, rd_ok;
  logic [PROG_W-1:0] progress;
  logic              ev_advance, ev_abort, ev_fire;
  logic              pulse_q;
  cmd_e              code_q;

  assign take  = acc_vld & ~busy;
  assign rd_ok = ~acc_wr & ~we_act;

  seqcmd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (acc_addr),
    .pre_hit  (pre_hit),
    .fin_hit  (fin_hit),
    .fin_code (fin_code)
  );

  seqcmd_tracker u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .rd_ok   (rd_ok),
    .pre_hit (pre_hit),
    .fin_hit (fin_hit),
    .prog_q  (progress),
    .advance (ev_advance),
    .abort   (ev_abort),
    .fire    (ev_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      code_q  <= CMD_SAVE;
    end else begin
      pulse_q <= ev_fire;
      if (ev_fire) code_q <= fin_code;
    end
  end

  assign cmd_vld  = pulse_q & ~busy;
  assign cmd_code = cmd_vld ? code_q : CMD_SAVE;
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk
  import seqcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic              we_act,
  input logic              busy,
  input logic              cmd_vld,
  input logic [1:0]        cmd_code,
  input logic [PROG_W-1:0] progress,
  input logic              ev_fire
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld); // R9
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_vld); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(progress)); // R10
  AST_FIRE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |-> progress == PROG_W'(NPRE)); // R2
  AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> progress == '0 && (cmd_vld || busy)); // R9
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !busy && (acc_wr || we_act)) |=> progress == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(progress)); // R11
  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |-> cmd_code == 2'd0); // R12
endmodule

bind seqcmd_detect seqcmd_detect_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_vld  (acc_vld),
  .acc_wr   (acc_wr),
  .we_act   (we_act),
  .busy     (busy),
  .cmd_vld  (cmd_vld),
  .cmd_code (cmd_code),
  .progress (progress),
  .ev_fire  (ev_fire)
);

// File: tb/seqcmd_detect_test.sv
module seqcmd_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0, acc_wr = 1'b0, we_act = 1'b0, busy = 1'b0;
  logic [16:0] acc_addr = '0;
  logic        cmd_vld;
  logic [1:0]  cmd_code;

  int n_run = 0, n_fail = 0;
  int mprog = 0;
  logic [15:0] chain [5];

  always #10 clk = ~clk;

  seqcmd_detect uut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr), .we_act(we_act),
    .acc_addr(acc_addr), .busy(busy), .cmd_vld(cmd_vld), .cmd_code(cmd_code)
  );

  function automatic int code_of(input logic [15:0] a);
    if (a == 16'h8FC0) return 0;
    if (a == 16'h4C63) return 1;
    if (a == 16'h8B45) return 2;
    if (a == 16'h4B46) return 3;
    return -1;
  endfunction

  // Drive one cycle, advance the behavioural model, compare after the edge.
  task automatic cyc(input logic v, input logic w, input logic we, input logic [16:0] a,
                     input string tag);
    int  ev = 0, ec = 0;
    logic [15:0] la;
    acc_vld = v; acc_wr = w; we_act = we; acc_addr = a;
    la = a[15:0];
    @(posedge clk);
    #1;
    if (!rst_n) mprog = 0;
    else if (v && !busy) begin
      if (w || we) mprog = 0;
      else if (mprog < 5 && la == chain[mprog]) mprog++;
      else if (mprog == 5 && code_of(la) >= 0) begin ev = 1; ec = code_of(la); mprog = 0; end
      else mprog = (la == chain[0]) ? 1 : 0;
    end
    n_run++;
    if (cmd_vld !== ev[0] || int'(cmd_code) != ec) begin
      n_fail++;
      $display("FAIL %s: vld=%0b code=%0d expected vld=%0b code=%0d", tag, cmd_vld, cmd_code, ev, ec);
    end
  endtask

  task automatic rd(input logic [16:0] a, input string tag);
    cyc(1'b1, 1'b0, 1'b0, a, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic chain_n(input int n, input string tag);
    for (int i = 0; i < n; i++) rd({1'b0, chain[i]}, tag);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    chain[0] = 16'h4E38; chain[1] = 16'hB1C7; chain[2] = 16'h83E0;
    chain[3] = 16'h7C1F; chain[4] = 16'h703F;
    idle("R1 reset");
    idle("R1 reset");
    rst_n = 1'b1;
    idle("R1 idle after reset");
    rd(17'h08FC0, "R1 lone final");
    // R2 save, with gaps (R11)
    chain_n(3, "R2 prefix");
    idle("R11 gap"); idle("R11 gap");
    rd(17'h07C1F, "R2 prefix"); rd(17'h0703F, "R2 prefix");
    rd(17'h08FC0, "R2 save");
    idle("R9 pulse gone");
    rd(17'h08FC0, "R9 final after cmd");
    // R3, R4
    chain_n(5, "R3 prefix"); rd(17'h04C63, "R3 restore"); idle("R3 after");
    chain_n(5, "R4 prefix"); rd(17'h08B45, "R4 auto off"); idle("R4 after");
    chain_n(5, "R4 prefix"); rd(17'h04B46, "R4 auto on"); idle("R4 after");
    // R5 wrong address
    chain_n(2, "R5 prefix"); rd(17'h01234, "R5 wrong");
    rd(17'h083E0, "R5 tail"); rd(17'h07C1F, "R5 tail"); rd(17'h0703F, "R5 tail");
    rd(17'h08FC0, "R5 no cmd");
    chain_n(5, "R5 prefix"); rd(17'h05555, "R5 wrong final");
    // R6 restart on first address
    chain_n(3, "R6 prefix"); rd(17'h04E38, "R6 restart");
    rd(17'h0B1C7, "R6"); rd(17'h083E0, "R6"); rd(17'h07C1F, "R6"); rd(17'h0703F, "R6");
    rd(17'h04C63, "R6 restore");
    // R7 writes
    chain_n(4, "R7 prefix"); cyc(1'b1, 1'b1, 1'b0, 17'h0703F, "R7 write cycle");
    rd(17'h08FC0, "R7 no cmd");
    chain_n(5, "R7 prefix"); cyc(1'b1, 1'b0, 1'b1, 17'h08FC0, "R7 we level");
    chain_n(5, "R7 prefix"); rd(17'h08FC0, "R7 clean save");
    // R8 upper bit ignored
    for (int i = 0; i < 5; i++) rd({1'b1, chain[i]}, "R8 prefix");
    rd(17'h18B45, "R8 auto off");
    // R10 busy
    chain_n(2, "R10 prefix");
    busy = 1'b1;
    rd(17'h01111, "R10 busy wrong"); rd(17'h083E0, "R10 busy step");
    busy = 1'b0;
    rd(17'h083E0, "R10"); rd(17'h07C1F, "R10"); rd(17'h0703F, "R10");
    busy = 1'b1; rd(17'h08FC0, "R10 busy final");
    busy = 1'b0; rd(17'h04B46, "R10 after busy");
    // R1 reset mid-chain
    chain_n(3, "R1 prefix");
    rst_n = 1'b0; idle("R1 reset mid"); rst_n = 1'b1;
    rd(17'h07C1F, "R1 tail"); rd(17'h0703F, "R1 tail"); rd(17'h08FC0, "R1 no cmd");
    idle("R12 idle code");
    summary();
  end
endmodule